// File: doc/BRIEF.md
# Shifted Second-Operand Generator

This block forms the second source operand for data-processing and move operations in a 32-bit datapath, along with the carry that the shift produces. There are three ways to form the operand. It can be an 8-bit constant rotated into place by an even amount. It can be a register passed through unchanged. It can be a register moved by one of five shift kinds, with the count taken from an instruction field or from the low byte of a second register.

The carry output is meant to load the carry flag when a flag-setting move or logical operation completes. An optional inversion stage turns the operand into its ones' complement for the move-negated case. The result is held in an output register, so an operand presented in one cycle appears on the outputs after the next rising clock edge.

Top module: `shift_operand_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `operand_q` and `carry_q` become zero. Otherwise the outputs show the result for the inputs that were present at the previous rising edge.
- R2: With `src_kind`=0 (immediate), the operand is `imm8` zero-extended to 32 bits, then rotated right by twice `rot4`.
- R3: For the immediate form, the carry is `carry_in` when `rot4` is zero. Otherwise it is bit 31 of the rotated constant.
- R4: With `src_kind`=1 (plain register), the operand is `rm_val` and the carry is `carry_in`.
- R5: With `src_kind`=2 (shifted register), `shift_op` selects the shift: 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate right. For a count n from 1 to 31, the carry is the last bit shifted out. That bit is rm[32-n] for a left shift and rm[n-1] for the right shifts and the rotate.
- R6: When `cnt_from_reg`=0, the count is `imm_cnt`. When it is 1, the count is `rs_val[7:0]`, and `rs_val[31:8]` has no effect.
- R7: A count of zero with shift kinds 0 to 3 leaves the operand equal to `rm_val` and the carry equal to `carry_in`.
- R8: A count of exactly 32 gives zero for the logical shifts, with carry rm[0] for a left shift and rm[31] for a right shift. A count above 32 gives zero with carry 0. An arithmetic right shift by 32 or more gives 32 copies of rm[31], with carry rm[31].
- R9: The rotate uses the count modulo 32. A nonzero count that is a multiple of 32 leaves the value unchanged and gives carry rm[31].
- R10: `shift_op`=4 is a one-bit rotate right through carry, whatever the count: `carry_in` enters bit 31, and rm[0] becomes the carry.
- R11: With `negate` high, the operand is the ones' complement of the value that would otherwise appear. The carry is not changed by the inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_kind | input | 2 | 0 immediate, 1 plain register, 2 shifted register |
| shift_op | input | 3 | 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate through carry |
| cnt_from_reg | input | 1 | Count source: 0 instruction field, 1 register |
| imm_cnt | input | 5 | Count from the instruction field |
| imm8 | input | 8 | Constant byte for the immediate form |
| rot4 | input | 4 | Half the rotate amount for the immediate form |
| rm_val | input | 32 | Value to be shifted |
| rs_val | input | 32 | Register supplying the count in its low byte |
| carry_in | input | 1 | Current carry flag |
| negate | input | 1 | Invert the operand (move-negated) |
| operand_q | output | 32 | Registered operand |
| carry_q | output | 1 | Registered shifter carry |

## Verification
The block holds no state except its output register, so a fault in it shows on the outputs one clock edge after the inputs that exercise it. Faults are most likely at the boundaries: a count of zero, a count of exactly 32 or just above it, a rotate count that wraps to zero, and a rotate code of zero for the immediate. At those points a wrong carry bit or a wrong fill is visible as soon as the next edge has passed. Random stimulus is weighted toward those counts, and each case is compared one edge later against a model built on double-width arithmetic.

// File: rtl/shop_pkg.sv
package shop_pkg;

  typedef enum logic [1:0] {
    OPK_IMM   = 2'd0,
    OPK_REG   = 2'd1,
    OPK_SHIFT = 2'd2,
    OPK_RSVD  = 2'd3
  } opkind_e;

  typedef enum logic [2:0] {
    SH_LSL  = 3'd0,
    SH_LSR  = 3'd1,
    SH_ASR  = 3'd2,
    SH_ROR  = 3'd3,
    SH_RRX  = 3'd4,
    SH_RSV5 = 3'd5,
    SH_RSV6 = 3'd6,
    SH_RSV7 = 3'd7
  } shkind_e;

endpackage

// File: rtl/shop_imm_rot.sv
module shop_imm_rot #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [ROT_W-1:0]  rot,
  input  logic              cin,
  output logic [DATA_W-1:0] val,
  output logic              cout
);

  localparam int AMT_W = ROT_W + 1;

  logic [DATA_W-1:0] zext;
  logic [AMT_W-1:0]  amt;

  assign zext = {{(DATA_W-IMM_W){1'b0}}, imm};
  assign amt  = {rot, 1'b0};

  // rotate right: result bit i takes source bit (i + amt) mod DATA_W
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      val[i] = zext[(i + int'(amt)) % DATA_W];
    end
  end

  assign cout = (rot == '0) ? cin : val[DATA_W-1];

endmodule

// File: rtl/shop_shift_core.sv
module shop_shift_core
  import shop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic [DATA_W-1:0] val,
  input  shkind_e           kind,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [IDX_W-1:0]  lo;
  logic              big;
  logic              exact;
  int                sh;
  logic [DATA_W-1:0] up_tap;
  logic [DATA_W-1:0] dn_tap;

  assign lo    = cnt[IDX_W-1:0];
  assign big   = (cnt >= FULL);
  assign exact = (cnt == FULL);
  assign sh    = int'(lo);

  // taps used to pick the last bit shifted out
  always_comb begin
    up_tap = val >> (DATA_W - sh);
    dn_tap = (sh == 0) ? val : (val >> (sh - 1));
  end

  always_comb begin
    res  = val;
    cout = cin;
    if (kind == SH_RRX) begin
      res  = {cin, val[DATA_W-1:1]};
      cout = val[0];
    end else if (cnt != '0) begin
      case (kind)
        SH_LSL: begin
          if (!big) begin
            res  = val << sh;
            cout = up_tap[0];
          end else begin
            res  = '0;
            cout = exact ? val[0] : 1'b0;
          end
        end
        SH_LSR: begin
          if (!big) begin
            res  = val >> sh;
            cout = dn_tap[0];
          end else begin
            res  = '0;
            cout = exact ? val[DATA_W-1] : 1'b0;
          end
        end
        SH_ASR: begin
          if (!big) begin
            res  = DATA_W'($signed(val) >>> sh);
            cout = dn_tap[0];
          end else begin
            res  = {DATA_W{val[DATA_W-1]}};
            cout = val[DATA_W-1];
          end
        end
        SH_ROR: begin
          if (lo == '0) begin
            res  = val;
            cout = val[DATA_W-1];
          end else begin
            res  = (val >> sh) | (val << (DATA_W - sh));
            cout = dn_tap[0];
          end
        end
        default: begin
          res  = val;
          cout = cin;
        end
      endcase
    end
  end

endmodule

// File: rtl/shop_out_stage.sv
module shop_out_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] d_val,
  input  logic              d_c,
  input  logic              negate,
  output logic [DATA_W-1:0] q_val,
  output logic              q_c
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_val <= '0;
      q_c   <= 1'b0;
    end else begin
      q_val <= negate ? ~d_val : d_val;
      q_c   <= d_c;
    end
  end

endmodule

// File: rtl/shift_operand_unit.sv
module shift_operand_unit
  import shop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int ICNT_W = 5,
  parameter int RCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        src_kind,
  input  logic [2:0]        shift_op,
  input  logic              cnt_from_reg,
  input  logic [ICNT_W-1:0] imm_cnt,
  input  logic [IMM_W-1:0]  imm8,
  input  logic [ROT_W-1:0]  rot4,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [DATA_W-1:0] rs_val,
  input  logic              carry_in,
  input  logic              negate,
  output logic [DATA_W-1:0] operand_q,
  output logic              carry_q
);

  opkind_e           kind;
  logic [RCNT_W-1:0] cnt;
  logic [DATA_W-1:0] imm_val, sh_val, pick_val;
  logic              imm_c, sh_c, pick_c;
  logic              unused_rs_hi;

  assign kind         = opkind_e'(src_kind);
  assign cnt          = cnt_from_reg ? rs_val[RCNT_W-1:0]
                                     : {{(RCNT_W-ICNT_W){1'b0}}, imm_cnt};
  assign unused_rs_hi = ^rs_val[DATA_W-1:RCNT_W];

  shop_imm_rot #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
  ) u_imm (
    .imm (imm8),
    .rot (rot4),
    .cin (carry_in),
    .val (imm_val),
    .cout(imm_c)
  );

  shop_shift_core #(
    .DATA_W(DATA_W), .CNT_W(RCNT_W)
  ) u_core (
    .val (rm_val),
    .kind(shkind_e'(shift_op)),
    .cnt (cnt),
    .cin (carry_in),
    .res (sh_val),
    .cout(sh_c)
  );

  always_comb begin
    case (kind)
      OPK_IMM:   begin pick_val = imm_val; pick_c = imm_c;    end
      OPK_SHIFT: begin pick_val = sh_val;  pick_c = sh_c;     end
      default:   begin pick_val = rm_val;  pick_c = carry_in; end
    endcase
  end

  shop_out_stage #(
    .DATA_W(DATA_W)
  ) u_out (
    .clk   (clk),
    .rst   (rst),
    .d_val (pick_val),
    .d_c   (pick_c),
    .negate(negate),
    .q_val (operand_q),
    .q_c   (carry_q)
  );

endmodule

// File: rtl/shop_checker.sv
module shop_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        src_kind,
  input logic [2:0]        shift_op,
  input logic              cnt_from_reg,
  input logic [7:0]        imm8,
  input logic [3:0]        rot4,
  input logic [DATA_W-1:0] rm_val,
  input logic [DATA_W-1:0] rs_val,
  input logic              carry_in,
  input logic              negate,
  input logic [DATA_W-1:0] operand_q,
  input logic              carry_q
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (operand_q == '0 && carry_q == 1'b0));

  // R4
  plain_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(src_kind) == 2'd1 && !$past(negate))
      |-> (operand_q == $past(rm_val) && carry_q == $past(carry_in)));

  // R3
  imm_norot_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(src_kind) == 2'd0 && $past(rot4) == 4'd0 && !$past(negate))
      |-> (operand_q == {{(DATA_W-8){1'b0}}, $past(imm8)} && carry_q == $past(carry_in)));

  // R10
  rrx_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(src_kind) == 2'd2 && $past(shift_op) == 3'd4 && !$past(negate))
      |-> (operand_q[DATA_W-1] == $past(carry_in) && carry_q == $past(rm_val[0])));

  // R8
  lsr_big_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(src_kind) == 2'd2 && $past(shift_op) == 3'd1 &&
     $past(cnt_from_reg) && $past(rs_val[7:0]) >= 8'd32 && !$past(negate))
      |-> (operand_q == '0));

  // R11
  negate_zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(src_kind) == 2'd2 && $past(shift_op) != 3'd4 &&
     $past(cnt_from_reg) && $past(rs_val[7:0]) == 8'd0 && $past(negate))
      |-> (operand_q == ~$past(rm_val) && carry_q == $past(carry_in)));

endmodule

bind shift_operand_unit shop_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .src_kind    (src_kind),
  .shift_op    (shift_op),
  .cnt_from_reg(cnt_from_reg),
  .imm8        (imm8),
  .rot4        (rot4),
  .rm_val      (rm_val),
  .rs_val      (rs_val),
  .carry_in    (carry_in),
  .negate      (negate),
  .operand_q   (operand_q),
  .carry_q     (carry_q)
);

// File: tb/shift_operand_unit_bench.sv
`timescale 1ns/1ps
module shift_operand_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  src_kind = '0;
  logic [2:0]  shift_op = '0;
  logic        cnt_from_reg = 1'b0;
  logic [4:0]  imm_cnt = '0;
  logic [7:0]  imm8 = '0;
  logic [3:0]  rot4 = '0;
  logic [31:0] rm_val = '0;
  logic [31:0] rs_val = '0;
  logic        carry_in = 1'b0;
  logic        negate = 1'b0;
  logic [31:0] operand_q;
  logic        carry_q;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  shift_operand_unit u_shift_operand_unit (
    .clk(clk), .rst(rst), .src_kind(src_kind), .shift_op(shift_op),
    .cnt_from_reg(cnt_from_reg), .imm_cnt(imm_cnt), .imm8(imm8), .rot4(rot4),
    .rm_val(rm_val), .rs_val(rs_val), .carry_in(carry_in), .negate(negate),
    .operand_q(operand_q), .carry_q(carry_q)
  );

  // reference model: returns {carry, value}
  function automatic logic [32:0] model(
    input logic [1:0] k, input logic [2:0] op, input logic fr, input logic [4:0] ic,
    input logic [7:0] i8, input logic [3:0] r4, input logic [31:0] rm,
    input logic [31:0] rs, input logic ci, input logic ng);
    logic [63:0] w;
    logic [31:0] v;
    logic        c;
    int          n;
    n = fr ? int'(rs[7:0]) : int'(ic);
    v = rm; c = ci;
    if (k == 2'd0) begin
      w = {24'd0, i8, 24'd0, i8} >> (2 * int'(r4));
      v = w[31:0];
      c = (r4 == 0) ? ci : v[31];
    end else if (k == 2'd2) begin
      if (op == 3'd4) begin
        v = {ci, rm[31:1]}; c = rm[0];
      end else if (n != 0) begin
        case (op)
          3'd0: begin w = {32'd0, rm} << n; v = w[31:0]; c = w[32]; end
          3'd1: begin w = {rm, 32'd0} >> n; v = w[63:32]; c = w[31]; end
          3'd2: begin
            w = 64'($signed({rm, 32'd0}) >>> ((n > 63) ? 63 : n));
            v = w[63:32]; c = w[31];
          end
          3'd3: begin
            if (n % 32 == 0) begin v = rm; c = rm[31]; end
            else begin w = {rm, rm} >> (n % 32); v = w[31:0]; c = v[31]; end
          end
          default: ;
        endcase
      end
    end
    if (ng) v = ~v;
    return {c, v};
  endfunction

  task automatic check(input string tag, input logic [31:0] ev, input logic ec);
    total++;
    if (operand_q !== ev || carry_q !== ec) begin
      bad++;
      $display("FAIL %s: got operand=%h carry=%b expected operand=%h carry=%b",
               tag, operand_q, carry_q, ev, ec);
    end
  endtask

  task automatic run(input string tag, input logic [1:0] k, input logic [2:0] op,
                     input logic fr, input logic [4:0] ic, input logic [7:0] i8,
                     input logic [3:0] r4, input logic [31:0] rm, input logic [31:0] rs,
                     input logic ci, input logic ng);
    logic [32:0] e;
    @(negedge clk);
    src_kind = k; shift_op = op; cnt_from_reg = fr; imm_cnt = ic; imm8 = i8;
    rot4 = r4; rm_val = rm; rs_val = rs; carry_in = ci; negate = ng;
    e = model(k, op, fr, ic, i8, r4, rm, rs, ci, ng);
    @(posedge clk);
    #2;
    check(tag, e[31:0], e[32]);
  endtask

  // fixed-value checks against hand-computed results
  task automatic run_fixed(input string tag, input logic [1:0] k, input logic [2:0] op,
                           input logic [7:0] i8, input logic [3:0] r4,
                           input logic [31:0] rm, input logic [31:0] rs,
                           input logic ci, input logic ng,
                           input logic [31:0] ev, input logic ec);
    @(negedge clk);
    src_kind = k; shift_op = op; cnt_from_reg = 1'b1; imm_cnt = '0; imm8 = i8;
    rot4 = r4; rm_val = rm; rs_val = rs; carry_in = ci; negate = ng;
    @(posedge clk);
    #2;
    check(tag, ev, ec);
  endtask

  function automatic string tag_of(input logic [1:0] k, input logic [2:0] op,
                                   input int n, input logic ng);
    if (ng) return "R11";
    if (k == 2'd0) return "R2";
    if (k != 2'd2) return "R4";
    if (op == 3'd4) return "R10";
    if (n == 0) return "R7";
    if (op == 3'd3 && n >= 32) return "R9";
    if (n >= 32) return "R8";
    return "R5";
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got running expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    // R1 reset state
    rm_val = 32'hDEADBEEF; src_kind = 2'd1; carry_in = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", 32'd0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R2 / R3 immediate
    run_fixed("R2 imm rot4=4", 2'd0, 3'd0, 8'hFF, 4'd4, 0, 0, 1'b0, 1'b0, 32'hFF00_0000, 1'b1);
    run_fixed("R3 imm rot4=0", 2'd0, 3'd0, 8'h5A, 4'd0, 0, 0, 1'b1, 1'b0, 32'h0000_005A, 1'b1);
    run_fixed("R3 imm rot bit31 clear", 2'd0, 3'd0, 8'h01, 4'd1, 0, 0, 1'b1, 1'b0, 32'h4000_0000, 1'b0);
    run_fixed("R2 imm rot4=15", 2'd0, 3'd0, 8'hC3, 4'd15, 0, 0, 1'b0, 1'b0, 32'h0000_030C, 1'b0);
    // R4 plain register
    run_fixed("R4 plain", 2'd1, 3'd2, 8'h00, 4'd0, 32'h1234_5678, 32'd5, 1'b1, 1'b0, 32'h1234_5678, 1'b1);
    // R5 basic shifts
    run_fixed("R5 lsl 4", 2'd2, 3'd0, 0, 0, 32'hF000_000F, 32'd4, 1'b0, 1'b0, 32'h0000_00F0, 1'b1);
    run_fixed("R5 asr 4", 2'd2, 3'd2, 0, 0, 32'h8000_0010, 32'd4, 1'b0, 1'b0, 32'hF800_0001, 1'b0);
    // R7 zero count
    run_fixed("R7 zero cnt", 2'd2, 3'd1, 0, 0, 32'hCAFE_F00D, 32'h0000_1100, 1'b1, 1'b0, 32'hCAFE_F00D, 1'b1);
    // R8 boundaries
    run_fixed("R8 lsr 32", 2'd2, 3'd1, 0, 0, 32'h8000_0001, 32'd32, 1'b0, 1'b0, 32'h0, 1'b1);
    run_fixed("R8 lsl 32", 2'd2, 3'd0, 0, 0, 32'h8000_0001, 32'd32, 1'b0, 1'b0, 32'h0, 1'b1);
    run_fixed("R8 lsl 33", 2'd2, 3'd0, 0, 0, 32'hFFFF_FFFF, 32'd33, 1'b1, 1'b0, 32'h0, 1'b0);
    run_fixed("R8 asr 40", 2'd2, 3'd2, 0, 0, 32'h8000_0000, 32'd40, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1);
    // R9 rotate modulo
    run_fixed("R9 ror 32", 2'd2, 3'd3, 0, 0, 32'h8000_0000, 32'd32, 1'b0, 1'b0, 32'h8000_0000, 1'b1);
    run_fixed("R9 ror 36", 2'd2, 3'd3, 0, 0, 32'h0000_0018, 32'd36, 1'b0, 1'b0, 32'h8000_0001, 1'b1);
    // R10 rotate through carry
    run_fixed("R10 rrx", 2'd2, 3'd4, 0, 0, 32'h0000_0003, 32'd9, 1'b0, 1'b0, 32'h0000_0001, 1'b1);
    run_fixed("R10 rrx cin", 2'd2, 3'd4, 0, 0, 32'h0000_0002, 32'd0, 1'b1, 1'b0, 32'h8000_0001, 1'b0);
    // R11 negate
    run_fixed("R11 negate plain", 2'd1, 3'd0, 0, 0, 32'h0F0F_0F0F, 0, 1'b1, 1'b1, 32'hF0F0_F0F0, 1'b1);
    run_fixed("R11 negate imm", 2'd0, 3'd0, 8'hFF, 4'd4, 0, 0, 1'b0, 1'b1, 32'h00FF_FFFF, 1'b1);
    // R6 count source: field vs register low byte with upper bits set
    run("R6 field cnt", 2'd2, 3'd1, 1'b0, 5'd4, 0, 0, 32'hABCD_0018, 32'hFFFF_FF00, 1'b0, 1'b0);
    run("R6 reg cnt", 2'd2, 3'd1, 1'b1, 5'd0, 0, 0, 32'hABCD_0018, 32'hFFFF_FF04, 1'b0, 1'b0);
    run_fixed("R6 reg cnt hi ignored", 2'd2, 3'd0, 0, 0, 32'h0000_0001, 32'h7F00_0001, 1'b0, 1'b0, 32'h0000_0002, 1'b0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] k;
      logic [2:0] op;
      logic       fr;
      logic [31:0] rs;
      logic [4:0] ic;
      int         n;
      int         pick;
      k  = 2'($urandom % 3);
      op = 3'($urandom % 5);
      fr = 1'($urandom);
      ic = 5'($urandom);
      rs = $urandom;
      pick = int'($urandom % 8);
      case (pick)
        0: rs[7:0] = 8'd0;
        1: rs[7:0] = 8'd32;
        2: rs[7:0] = 8'd33;
        3: rs[7:0] = 8'd64;
        4: rs[7:0] = 8'($urandom % 32);
        default: ;
      endcase
      if (pick == 0) ic = 5'd0;
      n = fr ? int'(rs[7:0]) : int'(ic);
      run(tag_of(k, op, n, 1'($urandom % 4 == 0) & 1'b0) , k, op, fr, ic, 8'($urandom),
          4'($urandom), $urandom, rs, 1'($urandom), 1'b0);
      if (i % 5 == 0)
        run("R11 random", k, op, fr, ic, 8'($urandom), 4'($urandom), $urandom, rs,
            1'($urandom), 1'b1);
    end

    // R1 reset again mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R1 reset mid-run", 32'd0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule